// File: doc/BRIEF.md
# I/Q Digital Gain and Offset Stage

This block sits in a transmit datapath and conditions the in-phase (I) and quadrature (Q) sample streams. Each lane multiplies its sample by its own 9-bit unsigned gain code divided by 128, so the gain runs from 0 to 3.9921875. The scaled value is rounded to the nearest integer. A signed 16-bit DC offset is then added, and the sum is clamped to the signed 16-bit range.

The gain code 0x80 means a gain of exactly one. For that code the lane skips the multiplier and applies only the offset. This short path takes one clock, while the multiplying path takes two. If only one lane is set to unity gain, the I and Q outputs no longer line up in time. A status output raises a flag whenever the two lanes use different paths.

The gain and offset inputs are meant to be static. They change only while no samples are in flight.

Top module: `iqgo_top`

## Requirements
- R1: While reset is high and on the first cycle after it, both output valids are low and both output samples are zero.
- R2: For a gain code other than 0x80, a sample accepted at one rising edge appears on the lane output two rising edges later. Its value is round(x*code/128) plus the offset. Rounding adds 64 before an arithmetic shift right by 7, so halves round toward positive infinity.
- R3: For gain code 0x80, a sample appears one rising edge after it is accepted, with the value x plus the offset.
- R4: The offset is a two's complement value. It is added after scaling, not before.
- R5: The sum of the scaled value and the offset saturates at 32767 and -32768. It never wraps.
- R6: A lane's output valid rises exactly once per accepted sample, at the latency of the path that lane currently uses. No valid appears at the other latency.
- R7: The I and Q lanes use separate gain codes and offsets. The settings of one lane never affect the result of the other.
- R8: `lat_mismatch` is high exactly when one gain code equals 0x80 and the other does not. While it is low, the two lane valids are equal on every cycle.
- R9: A gain code of zero makes the lane output equal to its offset for any input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An I/Q sample pair is present |
| in_i | input | 16 | I sample, two's complement |
| in_q | input | 16 | Q sample, two's complement |
| gain_i | input | 9 | I gain code (value/128) |
| gain_q | input | 9 | Q gain code (value/128) |
| offset_i | input | 16 | I DC offset, two's complement |
| offset_q | input | 16 | Q DC offset, two's complement |
| out_i | output | 16 | Conditioned I sample |
| out_i_valid | output | 1 | out_i holds a result |
| out_q | output | 16 | Conditioned Q sample |
| out_q_valid | output | 1 | out_q holds a result |
| lat_mismatch | output | 1 | The lanes use paths of different latency |

## Verification
The assertions assume that the gain codes and offsets do not change while a sample is between the input and the output. The latency and pass-through properties depend on the path that is selected at the output edge, so they only hold under that assumption. The bench therefore changes configuration only after the previous pulse has drained. It sends single isolated pulses, so each result is checked at its own latency. The bench sweeps all 512 I gain codes, paired with the mirrored Q codes, over a fixed set of edge-case samples.

// File: rtl/iqgo_pkg.sv
package iqgo_pkg;

    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_GAIN_W   = 9;
    localparam int DEF_FRAC_W   = 7;

    typedef enum logic {
        PATH_MUL = 1'b0,
        PATH_BYP = 1'b1
    } path_e;

    function automatic path_e select_path(input logic [31:0] code, input int frac_w);
        return (code == (32'd1 << frac_w)) ? PATH_BYP : PATH_MUL;
    endfunction

endpackage

// File: rtl/iqgo_mul_round.sv
module iqgo_mul_round
    import iqgo_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int GAIN_W   = DEF_GAIN_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    localparam int PROD_W  = SAMPLE_W + GAIN_W + 1,
    localparam int SCALE_W = PROD_W - FRAC_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_x,
    input  logic [GAIN_W-1:0]          gain,
    output logic                       out_vld,
    output logic signed [SCALE_W-1:0]  out_v
);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] gain_ext;

    always_comb begin
        gain_ext = PROD_W'($signed({1'b0, gain}));
        prod     = PROD_W'(in_x) * gain_ext;
        biased   = prod + PROD_W'(1 << (FRAC_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_v   <= '0;
        end else begin
            out_vld <= in_vld;
            out_v   <= biased[PROD_W-1:FRAC_W];
        end
    end

endmodule

// File: rtl/iqgo_offset_sat.sv
module iqgo_offset_sat
    import iqgo_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int ADD_W    = DEF_SAMPLE_W + 3,
    localparam int SUM_W   = ADD_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic signed [ADD_W-1:0]    in_v,
    input  logic signed [SAMPLE_W-1:0] offset,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_y
);

    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'sd1 <<< (SAMPLE_W - 1)) - 64'sd1);
    localparam logic signed [SUM_W-1:0] MIN_V = -MAX_V - SUM_W'(1);

    logic signed [SUM_W-1:0]    sum;
    logic signed [SAMPLE_W-1:0] clamped;

    always_comb begin
        sum = SUM_W'(in_v) + SUM_W'(offset);
        if (sum > MAX_V)
            clamped = MAX_V[SAMPLE_W-1:0];
        else if (sum < MIN_V)
            clamped = MIN_V[SAMPLE_W-1:0];
        else
            clamped = sum[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_y   <= '0;
        end else begin
            out_vld <= in_vld;
            out_y   <= clamped;
        end
    end

endmodule

// File: rtl/iqgo_channel.sv
module iqgo_channel
    import iqgo_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int GAIN_W   = DEF_GAIN_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    localparam int SCALE_W = SAMPLE_W + GAIN_W + 1 - FRAC_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_vld,
    input  logic signed [SAMPLE_W-1:0] in_x,
    input  logic [GAIN_W-1:0]          gain,
    input  logic signed [SAMPLE_W-1:0] offset,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_y,
    output logic                       bypass
);

    path_e path;

    logic                       scl_vld;
    logic signed [SCALE_W-1:0]  scl_v;
    logic                       mul_vld;
    logic signed [SAMPLE_W-1:0] mul_y;
    logic                       byp_vld;
    logic signed [SAMPLE_W-1:0] byp_y;

    always_comb begin
        path   = select_path(32'(gain), FRAC_W);
        bypass = (path == PATH_BYP);
    end

    iqgo_mul_round #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_mul (
        .clk(clk), .rst(rst),
        .in_vld(in_vld && !bypass), .in_x(in_x), .gain(gain),
        .out_vld(scl_vld), .out_v(scl_v)
    );

    iqgo_offset_sat #(.SAMPLE_W(SAMPLE_W), .ADD_W(SCALE_W)) u_mul_ofs (
        .clk(clk), .rst(rst),
        .in_vld(scl_vld), .in_v(scl_v), .offset(offset),
        .out_vld(mul_vld), .out_y(mul_y)
    );

    iqgo_offset_sat #(.SAMPLE_W(SAMPLE_W), .ADD_W(SCALE_W)) u_byp_ofs (
        .clk(clk), .rst(rst),
        .in_vld(in_vld && bypass), .in_v(SCALE_W'(in_x)), .offset(offset),
        .out_vld(byp_vld), .out_y(byp_y)
    );

    always_comb begin
        if (path == PATH_BYP) begin
            out_vld = byp_vld;
            out_y   = byp_y;
        end else begin
            out_vld = mul_vld;
            out_y   = mul_y;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_vld && out_y == '0));

    // R3
    byp_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && in_vld) |=> (!bypass || out_vld));

    // R3
    byp_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass && in_vld && offset == '0) |=> (!bypass || out_y == $past(in_x)));

    // R6
    mul_two_clk_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !bypass) |-> $past(in_vld, 2));

    // R6
    mul_not_early_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && in_vld && !$past(in_vld)) |=> (bypass || !out_vld));

    // R9
    zero_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (gain == '0 && in_vld) |=> ##1 (gain != '0 || !$stable(offset) || out_y == offset));

endmodule

// File: rtl/iqgo_top.sv
module iqgo_top
    import iqgo_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int GAIN_W   = DEF_GAIN_W,
    parameter int FRAC_W   = DEF_FRAC_W,
    localparam int N_LANES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    input  logic [GAIN_W-1:0]          gain_i,
    input  logic [GAIN_W-1:0]          gain_q,
    input  logic signed [SAMPLE_W-1:0] offset_i,
    input  logic signed [SAMPLE_W-1:0] offset_q,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic                       out_i_valid,
    output logic signed [SAMPLE_W-1:0] out_q,
    output logic                       out_q_valid,
    output logic                       lat_mismatch
);

    logic signed [SAMPLE_W-1:0] lane_x   [N_LANES];
    logic [GAIN_W-1:0]          lane_g   [N_LANES];
    logic signed [SAMPLE_W-1:0] lane_ofs [N_LANES];
    logic signed [SAMPLE_W-1:0] lane_y   [N_LANES];
    logic                       lane_vld [N_LANES];
    logic                       lane_byp [N_LANES];

    always_comb begin
        lane_x[0]   = in_i;
        lane_x[1]   = in_q;
        lane_g[0]   = gain_i;
        lane_g[1]   = gain_q;
        lane_ofs[0] = offset_i;
        lane_ofs[1] = offset_q;
    end

    for (genvar c = 0; c < N_LANES; c++) begin : g_lane
        iqgo_channel #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_ch (
            .clk(clk), .rst(rst),
            .in_vld(in_valid), .in_x(lane_x[c]), .gain(lane_g[c]), .offset(lane_ofs[c]),
            .out_vld(lane_vld[c]), .out_y(lane_y[c]), .bypass(lane_byp[c])
        );
    end

    always_comb begin
        out_i        = lane_y[0];
        out_i_valid  = lane_vld[0];
        out_q        = lane_y[1];
        out_q_valid  = lane_vld[1];
        lat_mismatch = lane_byp[0] ^ lane_byp[1];
    end

    // R8
    lanes_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (!lat_mismatch && $stable(gain_i) && $stable(gain_q)) |-> (out_i_valid == out_q_valid));

endmodule

// File: tb/iqgo_top_tb_top.sv
module iqgo_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic [8:0] gain_i = 9'd0, gain_q = 9'd0;
    logic signed [15:0] offset_i = '0, offset_q = '0;
    logic signed [15:0] out_i, out_q;
    logic out_i_valid, out_q_valid, lat_mismatch;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iqgo_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .gain_i(gain_i), .gain_q(gain_q), .offset_i(offset_i), .offset_q(offset_q),
        .out_i(out_i), .out_i_valid(out_i_valid), .out_q(out_q), .out_q_valid(out_q_valid),
        .lat_mismatch(lat_mismatch)
    );

    function automatic int model(int x, int g, int ofs);
        int p, q, r;
        if (g == 128) r = x;
        else begin
            p = x * g;
            q = p + 64;
            r = (q >= 0) ? q / 128 : -((-q + 127) / 128);
        end
        r = r + ofs;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input int xi, input int xq, input string dtag_i, input string dtag_q);
        int ei, eq;
        bit bi, bq;
        bi = (gain_i == 9'd128);
        bq = (gain_q == 9'd128);
        ei = model(xi, int'(gain_i), int'(offset_i));
        eq = model(xq, int'(gain_q), int'(offset_q));
        @(negedge clk);
        in_valid = 1'b1; in_i = 16'(xi); in_q = 16'(xq);
        @(negedge clk);
        in_valid = 1'b0;
        for (int st = 1; st <= 2; st++) begin
            check("R6 I valid", int'(out_i_valid), int'(bi ? st == 1 : st == 2));
            check("R6 Q valid", int'(out_q_valid), int'(bq ? st == 1 : st == 2));
            if (out_i_valid && (bi ? st == 1 : st == 2)) check(dtag_i, int'(out_i), ei);
            if (out_q_valid && (bq ? st == 1 : st == 2)) check(dtag_q, int'(out_q), eq);
            if (st == 1) @(negedge clk);
        end
    endtask

    function automatic string tag_for(int g);
        if (g == 128) return "R3 I/Q bypass value";
        if (g == 0) return "R9 zero gain value";
        return "R2 R7 scaled value";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int samp [8] = '{0, 1, -1, 32767, -32768, 12345, -20001, 63};
        repeat (3) @(negedge clk);
        // R1
        check("R1 out_i_valid", int'(out_i_valid), 0);
        check("R1 out_q_valid", int'(out_q_valid), 0);
        check("R1 out_i", int'(out_i), 0);
        check("R1 out_q", int'(out_q), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", int'(out_i_valid | out_q_valid), 0);

        for (int code = 0; code < 512; code++) begin
            gain_i = 9'(code);
            gain_q = 9'(511 - code);
            offset_i = (code % 4 == 0) ? 16'sd0 : 16'((code * 131) % 65536);
            offset_q = (code % 3 == 0) ? 16'sd0 : 16'(-(code * 77));
            @(negedge clk);
            // R8
            check("R8 lat_mismatch", int'(lat_mismatch),
                  int'((code == 128) != ((511 - code) == 128)));
            for (int k = 0; k < 8; k++)
                pulse(samp[k], samp[7 - k], tag_for(code), tag_for(511 - code));
        end

        // R8 both unity: aligned
        gain_i = 9'd128; gain_q = 9'd128; offset_i = 16'sd7; offset_q = -16'sd9;
        @(negedge clk);
        check("R8 both unity", int'(lat_mismatch), 0);
        pulse(1000, -1000, "R3 I unity", "R3 Q unity");

        // R4: offset after scaling (64/128 * 101 = 50.5 -> 51, then -5)
        gain_i = 9'd64; gain_q = 9'd200; offset_i = -16'sd5; offset_q = 16'sd3;
        @(negedge clk);
        check("R8 both mul", int'(lat_mismatch), 0);
        pulse(101, -3, "R4 offset after gain I", "R4 R2 Q round");
        check("R4 I literal", int'(model(101, 64, -5)), 46);

        // R5: saturation both ends
        gain_i = 9'd511; gain_q = 9'd511; offset_i = 16'sd32767; offset_q = -16'sd32768;
        @(negedge clk);
        pulse(32767, -32768, "R5 sat high", "R5 sat low");
        gain_i = 9'd128; gain_q = 9'd128; offset_i = 16'sd32767; offset_q = -16'sd32768;
        @(negedge clk);
        pulse(100, -100, "R5 R3 bypass sat high", "R5 R3 bypass sat low");

        // R7: I settings do not disturb Q
        gain_q = 9'd37; offset_q = 16'sd11;
        for (int g = 0; g < 512; g += 73) begin
            gain_i = 9'(g); offset_i = 16'(g * 13);
            @(negedge clk);
            pulse(-777, 4321, "R7 I lane", "R7 Q lane unaffected");
        end

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule